// File: doc/BRIEF.md
# Clock Request Arbitration Controller

This block is the control core of a four-output clock fan-out device. Each output has a request pin from its consumer. A request is corrected for its programmed polarity and gated by that output's enable bit to produce the output-enable for the matching clock buffer. The gated requests are then combined into one upstream request toward the master clock source. That upstream line is described as a drive value plus a drive-enable, so the pad can behave as a wired-OR (open-source), wired-AND (open-drain) or push-pull driver.

Configuration is loaded as a parallel word under a write strobe and held in the block. It holds enable bits, polarity bits and the upstream mode. A power-on reset returns all configuration to defaults. A separate active-low reset pin passes through a two-flop synchronizer and a low-duration filter. Once the filter accepts a low level, only the enable bits of the first and last output (outputs 1 and 4) are forced back on, and every other setting is left untouched. This block has no data stream, so all pins are plain levels with no valid/ready handshake.

Top module: `clkreq_ctrl`

## Requirements
- R1: After power-on reset, all enable bits are 1, all polarity bits are 0 (active-high) and the upstream mode is 0 (wired-OR).
- R2: clk_oe[i] is 1 exactly when the polarity-corrected request i is asserted and enable bit i is 1. The corrected request is req_i[i] XOR polarity bit i. This output is combinational from req_i.
- R3: With polarity bit i set to 1, request i is active-low.
- R4: A word presented with cfg_we high is stored on that clock edge and acts from the next cycle. cfg_en[i] and cfg_pol[i] belong to output i.
- R5: Mode 0 (wired-OR): when any clk_oe bit is 1, mreq_oe=1 and mreq_o=1. Otherwise mreq_oe=0.
- R6: Mode 1 (wired-AND): when no clk_oe bit is 1, mreq_oe=1 and mreq_o=0. Otherwise mreq_oe=0.
- R7: Mode 2 (push-pull): mreq_oe=1 always, and mreq_o is the OR of clk_oe.
- R8: Mode code 3 is reserved and behaves as mode 0.
- R9: If filt_rst_n stays low for FILT_CYCLES consecutive synchronized samples, enable bits 0 and 3 are set to 1. The polarity bits, the mode and enable bits 1 and 2 keep their values.
- R10: A low pulse on filt_rst_n shorter than the filter window changes no configuration bit.
- R11: While the filtered reset is active, a configuration write still updates every field, except that enable bits 0 and 3 stay at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Asynchronous power-on reset, active low; resets all configuration |
| filt_rst_n | input | 1 | Asynchronous partial reset pin, active low, deglitched |
| req_i | input | 4 | Per-output clock request pins |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_en | input | 4 | Enable bits to write, bit i for output i |
| cfg_pol | input | 4 | Polarity bits to write, 1 = active-low |
| cfg_mode | input | 2 | Upstream mode to write: 0 wired-OR, 1 wired-AND, 2 push-pull, 3 reserved |
| clk_oe | output | 4 | Output enables for the four clock buffers |
| mreq_o | output | 1 | Upstream request drive value |
| mreq_oe | output | 1 | Upstream request drive enable (0 = floating) |

## Verification
The hardest cases to reach are at the edges of the filter window. The stimulus holds filt_rst_n low for two cycles fewer than the window and then releases it, with the outer enables cleared beforehand, so any false acceptance shows up as an output-enable on an output that should stay off. The bench then holds the pin low well past the window and issues a write that clears every enable while the reset is still asserted. The forced outer outputs should stay on while the inner outputs and the polarity and mode fields take the new values.

// File: rtl/clkreq_pkg.sv
package clkreq_pkg;
  typedef enum logic [1:0] {
    MODE_WOR  = 2'd0,
    MODE_WAND = 2'd1,
    MODE_PP   = 2'd2,
    MODE_RSVD = 2'd3
  } up_mode_e;
endpackage

// File: rtl/clkreq_rst_filter.sv
module clkreq_rst_filter #(
  parameter int FILT_CYCLES = 30
) (
  input  logic clk,
  input  logic por_n,
  input  logic pin_n,
  output logic active
);
  localparam int CW = $clog2(FILT_CYCLES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(FILT_CYCLES);

  logic s1_q, s2_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      s1_q <= 1'b1;
      s2_q <= 1'b1;
    end else begin
      s1_q <= pin_n;
      s2_q <= s1_q;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)             cnt_q <= '0;
    else if (s2_q)          cnt_q <= '0;
    else if (cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
  end

  assign active = (cnt_q == LIMIT);

  AST_ACTIVE_NEEDS_LOW: assert property (@(posedge clk) disable iff (!por_n)
    active |-> $past(!s2_q)); // R10
  AST_HIGH_CLEARS: assert property (@(posedge clk) disable iff (!por_n)
    s2_q |=> !active); // R10
endmodule

// File: rtl/clkreq_cfg_regs.sv
module clkreq_cfg_regs
  import clkreq_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           por_n,
  input  logic           we,
  input  logic [NCH-1:0] d_en,
  input  logic [NCH-1:0] d_pol,
  input  logic [1:0]     d_mode,
  input  logic           force_outer,
  output logic [NCH-1:0] en_q,
  output logic [NCH-1:0] pol_q,
  output up_mode_e       mode_q
);
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      en_q   <= '1;
      pol_q  <= '0;
      mode_q <= MODE_WOR;
    end else begin
      if (we) begin
        en_q   <= d_en;
        pol_q  <= d_pol;
        mode_q <= up_mode_e'(d_mode);
      end
      if (force_outer) begin
        en_q[0]     <= 1'b1;
        en_q[NCH-1] <= 1'b1;
      end
    end
  end

  AST_OUTER_FORCED: assert property (@(posedge clk) disable iff (!por_n)
    force_outer |=> (en_q[0] && en_q[NCH-1])); // R9
  AST_POL_HOLDS: assert property (@(posedge clk) disable iff (!por_n)
    !we |=> $stable(pol_q)); // R9
  AST_MODE_HOLDS: assert property (@(posedge clk) disable iff (!por_n)
    !we |=> $stable(mode_q)); // R4
endmodule

// File: rtl/clkreq_drive.sv
module clkreq_drive
  import clkreq_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           por_n,
  input  logic [NCH-1:0] req,
  input  logic [NCH-1:0] en,
  input  logic [NCH-1:0] pol,
  input  up_mode_e       mode,
  output logic [NCH-1:0] oe,
  output logic           up_val,
  output logic           up_drv
);
  logic any_req;

  always_comb begin
    oe      = (req ^ pol) & en;
    any_req = |oe;
    unique case (mode)
      MODE_WAND: begin up_drv = ~any_req; up_val = 1'b0;    end
      MODE_PP:   begin up_drv = 1'b1;     up_val = any_req; end
      default:   begin up_drv = any_req;  up_val = any_req; end
    endcase
  end

  AST_OE_NEEDS_EN: assert property (@(posedge clk) disable iff (!por_n)
    (oe & ~en) == '0); // R2
  AST_WOR_NO_LOW: assert property (@(posedge clk) disable iff (!por_n)
    (mode != MODE_WAND && up_drv && mode != MODE_PP) |-> up_val); // R5
  AST_WAND_NO_HIGH: assert property (@(posedge clk) disable iff (!por_n)
    (mode == MODE_WAND && up_drv) |-> !up_val); // R6
  AST_PP_DRIVES: assert property (@(posedge clk) disable iff (!por_n)
    (mode == MODE_PP) |-> up_drv); // R7
endmodule

// File: rtl/clkreq_ctrl.sv
module clkreq_ctrl
  import clkreq_pkg::*;
#(
  parameter int NCH         = 4,
  parameter int FILT_CYCLES = 30
) (
  input  logic           clk,
  input  logic           por_n,
  input  logic           filt_rst_n,
  input  logic [NCH-1:0] req_i,
  input  logic           cfg_we,
  input  logic [NCH-1:0] cfg_en,
  input  logic [NCH-1:0] cfg_pol,
  input  logic [1:0]     cfg_mode,
  output logic [NCH-1:0] clk_oe,
  output logic           mreq_o,
  output logic           mreq_oe
);
  logic           filt_active;
  logic [NCH-1:0] en_q, pol_q;
  up_mode_e       mode_q;

  clkreq_rst_filter #(.FILT_CYCLES(FILT_CYCLES)) u_filt (
    .clk(clk), .por_n(por_n), .pin_n(filt_rst_n), .active(filt_active)
  );

  clkreq_cfg_regs #(.NCH(NCH)) u_cfg (
    .clk(clk), .por_n(por_n), .we(cfg_we), .d_en(cfg_en), .d_pol(cfg_pol),
    .d_mode(cfg_mode), .force_outer(filt_active),
    .en_q(en_q), .pol_q(pol_q), .mode_q(mode_q)
  );

  clkreq_drive #(.NCH(NCH)) u_drv (
    .clk(clk), .por_n(por_n), .req(req_i), .en(en_q), .pol(pol_q),
    .mode(mode_q), .oe(clk_oe), .up_val(mreq_o), .up_drv(mreq_oe)
  );

  AST_FLOAT_IMPLIES_NO_PP: assert property (@(posedge clk) disable iff (!por_n)
    !mreq_oe |-> (mode_q != MODE_PP)); // R7
  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!por_n)
    (cfg_we && !filt_active) |=> (en_q == $past(cfg_en))); // R4
endmodule

// File: tb/clkreq_ctrl_tb.sv
module clkreq_ctrl_tb;
  localparam int NCH = 4;
  localparam int FC  = 30;

  logic clk = 1'b0;
  logic por_n = 1'b0;
  logic filt_rst_n = 1'b1;
  logic [3:0] req_i = '0;
  logic cfg_we = 1'b0;
  logic [3:0] cfg_en = '0, cfg_pol = '0;
  logic [1:0] cfg_mode = '0;
  logic [3:0] clk_oe;
  logic mreq_o, mreq_oe;

  int total = 0, bad = 0, cyc = 0;
  logic [3:0] m_en = 4'hF, m_pol = 4'h0;
  logic [1:0] m_mode = 2'd0;

  logic [5:0] exp_q[$];
  string      tag_q[$];
  bit         done = 0;

  always #5 clk = ~clk;

  clkreq_ctrl #(.NCH(NCH), .FILT_CYCLES(FC)) u_dut (
    .clk(clk), .por_n(por_n), .filt_rst_n(filt_rst_n), .req_i(req_i),
    .cfg_we(cfg_we), .cfg_en(cfg_en), .cfg_pol(cfg_pol), .cfg_mode(cfg_mode),
    .clk_oe(clk_oe), .mreq_o(mreq_o), .mreq_oe(mreq_oe)
  );

  function automatic logic [5:0] model();
    logic [3:0] oe;
    logic any, v, d;
    oe  = (req_i ^ m_pol) & m_en;
    any = |oe;
    case (m_mode)
      2'd1:    begin d = ~any; v = 1'b0; end
      2'd2:    begin d = 1'b1; v = any;  end
      default: begin d = any;  v = any;  end
    endcase
    return {oe, v, d};
  endfunction

  task automatic expect_now(string tag);
    exp_q.push_back(model());
    tag_q.push_back(tag);
  endtask

  task automatic drive_req(logic [3:0] r);
    @(negedge clk); #1 req_i = r;
  endtask

  task automatic write_cfg(logic [3:0] e, logic [3:0] p, logic [1:0] m, bit forced);
    @(negedge clk); #1;
    cfg_we = 1'b1; cfg_en = e; cfg_pol = p; cfg_mode = m;
    @(negedge clk); #1 cfg_we = 1'b0;
    m_en = forced ? (e | 4'b1001) : e;
    m_pol = p; m_mode = m;
  endtask

  // monitor: pops expected items in the same half cycle the driver pushed them
  initial begin
    forever begin
      @(negedge clk); #2;
      while (exp_q.size() > 0) begin
        logic [5:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        total++;
        if ({clk_oe, mreq_o, mreq_oe} !== e) begin
          bad++;
          $display("FAIL %s: got oe=%b o=%b drv=%b exp oe=%b o=%b drv=%b",
                   t, clk_oe, mreq_o, mreq_oe, e[5:2], e[1], e[0]);
        end
      end
    end
  end

  initial begin
    forever begin
      @(posedge clk); cyc++;
      if (cyc > 100000 && !done) begin
        bad++; total++;
        $display("FAIL watchdog: got timeout exp completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    por_n = 1'b1;
    // R1 defaults
    drive_req(4'b0000); expect_now("R1 idle wired-OR floats");
    drive_req(4'b1111); expect_now("R1 all enabled active-high");
    // R2 varied requests
    drive_req(4'b0101); expect_now("R2 pattern 0101");
    write_cfg(4'b0110, 4'b0000, 2'd0, 0);
    drive_req(4'b1111); expect_now("R4 enable mask 0110");
    drive_req(4'b1001); expect_now("R2 disabled requests gated, R5 float");
    // R3 polarity
    write_cfg(4'b1111, 4'b0011, 2'd0, 0);
    drive_req(4'b0000); expect_now("R3 active-low on 0 and 1");
    drive_req(4'b0011); expect_now("R3 deasserted low-active");
    // R6 wired-AND
    write_cfg(4'b1111, 4'b0000, 2'd1, 0);
    drive_req(4'b0000); expect_now("R6 none -> drive low");
    drive_req(4'b0100); expect_now("R6 request -> float");
    // R7 push-pull
    write_cfg(4'b1111, 4'b0000, 2'd2, 0);
    drive_req(4'b0000); expect_now("R7 push-pull low");
    drive_req(4'b1000); expect_now("R7 push-pull high");
    // R8 reserved code
    write_cfg(4'b1111, 4'b0000, 2'd3, 0);
    drive_req(4'b0010); expect_now("R8 reserved as wired-OR drive");
    drive_req(4'b0000); expect_now("R8 reserved as wired-OR float");
    // R10 short pulse ignored
    write_cfg(4'b0000, 4'b0100, 2'd2, 0);
    drive_req(4'b1011);
    @(negedge clk); #1 filt_rst_n = 1'b0;
    repeat (FC - 2) @(negedge clk);
    #1 filt_rst_n = 1'b1;
    repeat (6) @(negedge clk);
    #1 expect_now("R10 short low pulse ignored");
    // R9 accepted reset
    @(negedge clk); #1 filt_rst_n = 1'b0;
    repeat (FC + 4) @(negedge clk);
    #1 m_en = m_en | 4'b1001;
    expect_now("R9 outer outputs forced on, rest kept");
    drive_req(4'b0111); expect_now("R9 polarity and mode kept");
    // R11 write while active
    write_cfg(4'b0000, 4'b0000, 2'd1, 1);
    drive_req(4'b1111); expect_now("R11 outer enables held during reset");
    drive_req(4'b0110); expect_now("R11 new mode applied, inner disabled");
    @(negedge clk); #1 filt_rst_n = 1'b1;
    repeat (4) @(negedge clk);
    write_cfg(4'b0000, 4'b0000, 2'd0, 0);
    drive_req(4'b1111); expect_now("R4 outer enables clear after release");
    @(negedge clk); @(negedge clk);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule